// File: doc/BRIEF.md
# Dual-Line Maskable Interrupt Controller

This block gathers single-cycle event pulses into two sticky status words and drives two active-low interrupt lines, line 0 and line 1. Each line has a mask word of its own. A status flag sets whenever its event fires, whatever its mask bit holds. A line goes low while at least one of its flags is set and enabled. Host software reaches the masks, the status words and a group of read-only detail words through a small register bus. The host clears status flags by writing ones to them.

Line 1 carries a reset-completion flag that no mask can silence. It sets once after the block leaves reset and again on each software-reset-done pulse. Some summary flags have a companion detail word that records which phase, out of `NPH` phases, raised the condition. Each detail bit is sticky. Clearing any of the summary flags that a detail word is tied to also clears that detail word. The host reads the summary word first and then the detail word.

Top module: `irq_dual_ctrl`

## Requirements
- R1: After reset both mask words read 0, status word 0 reads 0, every detail word reads 0 and `irq0_n` is high.
- R2: An event pulse on bit i sets status bit i on the next clock edge, whether mask bit i is 0 or 1. The bit then stays set.
- R3: An interrupt line is registered. It is low in the cycle after a cycle in which some status bit and its mask bit are both 1, and high otherwise. Bit 15 of line 1 is the exception covered in R6.
- R4: A write to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set. The same rule holds for detail bits.
- R6: Status word 1 bit 15 sets in the first cycle after reset is released and on every `sw_rst_done` pulse. While it is set, `irq1_n` goes low even when mask word 1 bit 15 is 0. Writing mask word 1 bit 15 changes nothing on the line.
- R7: Register map on `bus_addr`: 0 is mask word 0, 1 is mask word 1, 2 is status word 0, 3 is status word 1. A write to a mask word replaces it, and reads return the written value.
- R8: Detail words are read at addresses 4 to 8, one per group, with phase p at bit p, zero-extended. Group g takes its pulses on `det_ev[g*NPH+p]`, and each pulse sets the bit stickily.
- R9: Each detail group is tied to a set of summary bits. Group 0 uses status 0 bits 6 to 13 and 18. Group 1 uses status 1 bits 0 to 2. Group 2 uses status 1 bits 16 to 18. Group 3 uses status 1 bit 23. Group 4 uses status 1 bit 24. A status write with a 1 on any of a group's tied bits clears that group. A status write with ones only on other bits leaves the group as it was.
- R10: Writes to addresses 4 to 15 change no register. Addresses 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for `bus_addr` (combinational) |
| ev0 | input | W | Event pulses for status word 0 |
| ev1 | input | W | Event pulses for status word 1 |
| sw_rst_done | input | 1 | Pulse when a software reset completes |
| det_ev | input | 5*NPH | Per-phase detail pulses, group-major |
| irq0_n | output | 1 | Interrupt line 0, active low |
| irq1_n | output | 1 | Interrupt line 1, active low |

## Verification
The bench builds the block with its defaults, W = 32 and NPH = 3. At that size the bench can sweep every status bit of both lines through the whole sequence of set, masked-off, enabled, partial clear and full clear. It can also pulse every one of the fifteen phase inputs one at a time. Because the word is only 32 bits wide, the forced bit 15 and each detail group's tied bits fall inside the same sweep. The bench checks each of these against a tie table it holds itself.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NGRP    = 5;
  localparam int RDN_BIT = 15;

  localparam logic [3:0] RA_MASK0 = 4'd0;
  localparam logic [3:0] RA_MASK1 = 4'd1;
  localparam logic [3:0] RA_STAT0 = 4'd2;
  localparam logic [3:0] RA_STAT1 = 4'd3;
  localparam logic [3:0] RA_DET0  = 4'd4;

  // summary bits each detail group is tied to
  function automatic logic [31:0] grp_link(input int g);
    case (g)
      0:       grp_link = 32'h0004_3FC0;
      1:       grp_link = 32'h0000_0007;
      2:       grp_link = 32'h0007_0000;
      3:       grp_link = 32'h0080_0000;
      default: grp_link = 32'h0100_0000;
    endcase
  endfunction

  // 1: group tied to status word 1, 0: status word 0
  function automatic logic grp_on_line1(input int g);
    grp_on_line1 = (g != 0);
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int             W         = 32,
  parameter logic [W-1:0]   ALWAYS_ON = '0
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic         mask_we,
  input  logic         stat_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] ev,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] stat_q,
  output logic         irq_n
);
  logic [W-1:0] mask_d;
  logic [W-1:0] stat_d;
  logic [W-1:0] clr;
  logic         irq_n_d;

  always_comb begin
    mask_d  = mask_q;
    if (mask_we) mask_d = wdata;
    clr     = stat_we ? wdata : '0;
    stat_d  = (stat_q & ~clr) | ev;          // a new event beats a clear
    irq_n_d = ~|(stat_q & (mask_q | ALWAYS_ON));
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_n  <= 1'b1;
    end else begin
      mask_q <= mask_d;
      stat_q <= stat_d;
      irq_n  <= irq_n_d;
    end
  end
endmodule

// File: rtl/irq_detail.sv
module irq_detail #(
  parameter int NPH  = 3,
  parameter int NGRP = 5
) (
  input  logic                clk,
  input  logic                rst_sn,
  input  logic [NGRP*NPH-1:0] det_ev,
  input  logic [NGRP-1:0]     grp_clr,
  output logic [NGRP*NPH-1:0] det_q
);
  logic [NGRP*NPH-1:0] det_d;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign det_d[g*NPH +: NPH] =
      (grp_clr[g] ? {NPH{1'b0}} : det_q[g*NPH +: NPH]) | det_ev[g*NPH +: NPH];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) det_q <= '0;
    else         det_q <= det_d;
  end
endmodule

// File: rtl/irq_dual_ctrl.sv
module irq_dual_ctrl
  import irq_pkg::*;
#(
  parameter int W   = 32,
  parameter int NPH = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [W-1:0]        bus_wdata,
  output logic [W-1:0]        bus_rdata,
  input  logic [W-1:0]        ev0,
  input  logic [W-1:0]        ev1,
  input  logic                sw_rst_done,
  input  logic [NGRP*NPH-1:0] det_ev,
  output logic                irq0_n,
  output logic                irq1_n
);
  localparam int           DW       = NGRP * NPH;
  localparam logic [W-1:0] RDN_MASK = W'(1) << RDN_BIT;

  logic            rst_sn;
  logic            boot_q;
  logic            boot_d;
  logic            mask0_we, mask1_we, st0_we, st1_we;
  logic [W-1:0]    clr0, clr1, ev1_all;
  logic [W-1:0]    mask0_q, mask1_q, stat0_q, stat1_q;
  logic [NGRP-1:0] grp_clr;
  logic [DW-1:0]   det_q;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  // reset-done fires in the first cycle out of reset
  always_comb boot_d = 1'b1;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) boot_q <= 1'b0;
    else         boot_q <= boot_d;
  end

  always_comb begin
    mask0_we = bus_wr && (bus_addr == RA_MASK0);
    mask1_we = bus_wr && (bus_addr == RA_MASK1);
    st0_we   = bus_wr && (bus_addr == RA_STAT0);
    st1_we   = bus_wr && (bus_addr == RA_STAT1);
    clr0     = st0_we ? bus_wdata : '0;
    clr1     = st1_we ? bus_wdata : '0;
    ev1_all  = ev1 | ((!boot_q || sw_rst_done) ? RDN_MASK : '0);
  end

  irq_line #(.W(W), .ALWAYS_ON('0)) u_line0 (
    .clk(clk), .rst_sn(rst_sn), .mask_we(mask0_we), .stat_we(st0_we),
    .wdata(bus_wdata), .ev(ev0), .mask_q(mask0_q), .stat_q(stat0_q),
    .irq_n(irq0_n));

  irq_line #(.W(W), .ALWAYS_ON(RDN_MASK)) u_line1 (
    .clk(clk), .rst_sn(rst_sn), .mask_we(mask1_we), .stat_we(st1_we),
    .wdata(bus_wdata), .ev(ev1_all), .mask_q(mask1_q), .stat_q(stat1_q),
    .irq_n(irq1_n));

  for (genvar g = 0; g < NGRP; g++) begin : g_clr
    assign grp_clr[g] = |((grp_on_line1(g) ? clr1 : clr0) & W'(grp_link(g)));
  end

  irq_detail #(.NPH(NPH), .NGRP(NGRP)) u_det (
    .clk(clk), .rst_sn(rst_sn), .det_ev(det_ev), .grp_clr(grp_clr),
    .det_q(det_q));

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_MASK0: bus_rdata = mask0_q;
      RA_MASK1: bus_rdata = mask1_q;
      RA_STAT0: bus_rdata = stat0_q;
      RA_STAT1: bus_rdata = stat1_q;
      default: begin
        for (int g = 0; g < NGRP; g++) begin
          if (bus_addr == RA_DET0 + 4'(g)) bus_rdata = W'(det_q[g*NPH +: NPH]);
        end
      end
    endcase
  end
endmodule

// File: rtl/irq_dual_ctrl_chk.sv
module irq_dual_ctrl_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_sn,
  input logic [W-1:0] ev0,
  input logic [W-1:0] bus_wdata,
  input logic         st0_we,
  input logic [W-1:0] stat0,
  input logic [W-1:0] mask0,
  input logic [W-1:0] mask1,
  input logic [W-1:0] stat1,
  input logic         irq0_n,
  input logic         irq1_n
);
  p_masks_clear_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(rst_sn) |-> (mask0 == '0) && (mask1 == '0));

  p_sticky_set_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (ev0 != '0) |=> ((stat0 & $past(ev0)) == $past(ev0)));

  p_line_low_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    ((stat0 & mask0) != '0) |=> !irq0_n);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (!st0_we && ev0 == '0) |=> $stable(stat0));

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    st0_we |=> ((stat0 & $past(bus_wdata) & ~$past(ev0)) == '0));

  p_rdn_forced_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    stat1[15] |=> !irq1_n);
endmodule

bind irq_dual_ctrl irq_dual_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .ev0(ev0), .bus_wdata(bus_wdata),
  .st0_we(st0_we), .stat0(stat0_q), .mask0(mask0_q), .mask1(mask1_q),
  .stat1(stat1_q), .irq0_n(irq0_n), .irq1_n(irq1_n));

// File: tb/sim_irq_dual_ctrl.sv
`timescale 1ns/100ps
module sim_irq_dual_ctrl;
  localparam int W = 32;
  localparam int NPH = 3;
  localparam int NG = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    bus_addr;
  logic          bus_wr;
  logic [W-1:0]  bus_wdata, bus_rdata, ev0, ev1;
  logic          sw_rst_done;
  logic [NG*NPH-1:0] det_ev;
  logic          irq0_n, irq1_n;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_dual_ctrl #(.W(W), .NPH(NPH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev0(ev0), .ev1(ev1),
    .sw_rst_done(sw_rst_done), .det_ev(det_ev), .irq0_n(irq0_n), .irq1_n(irq1_n));

  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] tie_bits(input int g);
    case (g)
      0: tie_bits = (32'hFF << 6) | (32'h1 << 18);
      1: tie_bits = 32'h7;
      2: tie_bits = 32'h7 << 16;
      3: tie_bits = 32'h1 << 23;
      default: tie_bits = 32'h1 << 24;
    endcase
  endfunction

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [W-1:0] exp, input string tag);
    bus_addr = a; #1;
    chk(bus_rdata, exp, tag);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-reqs actual=timeout expected=done");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    ev0 = '0; ev1 = '0; sw_rst_done = 1'b0; det_ev = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    rd_chk(4'd0, '0, "R1 mask0");
    rd_chk(4'd1, '0, "R1 mask1");
    rd_chk(4'd2, '0, "R1 stat0");
    for (int g = 0; g < NG; g++) rd_chk(4'(4 + g), '0, "R1 detail");
    chk(W'(irq0_n), W'(1), "R1 irq0_n");
    // R6 reset-done after release
    rd_chk(4'd3, 32'h8000, "R6 stat1 boot");
    chk(W'(irq1_n), W'(0), "R6 irq1_n boot");
    wr(4'd3, 32'h8000);
    step();
    rd_chk(4'd3, '0, "R6 stat1 cleared");
    chk(W'(irq1_n), W'(1), "R6 irq1_n cleared");

    // R7 mask readback
    wr(4'd0, 32'hA5C3_0F81); rd_chk(4'd0, 32'hA5C3_0F81, "R7 mask0");
    wr(4'd1, 32'h1234_FEDC); rd_chk(4'd1, 32'h1234_FEDC, "R7 mask1");
    wr(4'd0, '0); wr(4'd1, '0);

    // R2 R3 R4 sweep every bit of both lines
    for (int l = 0; l < 2; l++) begin
      for (int i = 0; i < W; i++) begin
        logic [W-1:0] v;
        logic forced;
        v = W'(1) << i;
        forced = (l == 1) && (i == 15);
        if (l == 0) ev0 = v; else ev1 = v;
        step();
        ev0 = '0; ev1 = '0;
        rd_chk(4'(2 + l), v, "R2 set while masked");
        step();
        chk(W'(l == 0 ? irq0_n : irq1_n), W'(forced ? 0 : 1), "R3 masked line");
        wr(4'(l), v); step();
        chk(W'(l == 0 ? irq0_n : irq1_n), W'(0), "R3 enabled line low");
        wr(4'(l), ~v); step();
        chk(W'(l == 0 ? irq0_n : irq1_n), W'(forced ? 0 : 1), "R3 other bits only");
        wr(4'(2 + l), '0); rd_chk(4'(2 + l), v, "R4 zero write keeps");
        wr(4'(2 + l), ~v); rd_chk(4'(2 + l), v, "R4 others written");
        wr(4'(2 + l), v);  rd_chk(4'(2 + l), '0, "R4 one clears");
        wr(4'(l), '0); step();
        chk(W'(l == 0 ? irq0_n : irq1_n), W'(1), "R3 line released");
      end
    end

    // R5 set beats clear
    ev0 = 32'h8; bus_addr = 4'd2; bus_wdata = 32'h8; bus_wr = 1'b1;
    step();
    ev0 = '0; bus_wr = 1'b0;
    rd_chk(4'd2, 32'h8, "R5 status set wins");
    wr(4'd2, 32'h8);

    // R6 mask bit 15 has no effect, sw pulse forces line
    wr(4'd1, 32'h8000); step();
    chk(W'(irq1_n), W'(1), "R6 mask15 no effect");
    wr(4'd1, '0);
    sw_rst_done = 1'b1; step(); sw_rst_done = 1'b0;
    rd_chk(4'd3, 32'h8000, "R6 sw pulse sets");
    step();
    chk(W'(irq1_n), W'(0), "R6 unmaskable low");
    wr(4'd3, 32'h8000); step();
    chk(W'(irq1_n), W'(1), "R6 released");

    // R8 detail sweep
    for (int g = 0; g < NG; g++) begin
      for (int p = 0; p < NPH; p++) begin
        det_ev = '0; det_ev[g*NPH + p] = 1'b1;
        step(); det_ev = '0;
        rd_chk(4'(4 + g), W'((1 << (p + 1)) - 1), "R8 detail sticky");
      end
    end

    // R9 untied clears leave detail
    wr(4'd2, ~tie_bits(0));
    rd_chk(4'd4, W'(7), "R9 group0 untied write");
    wr(4'd3, ~(tie_bits(1) | tie_bits(2) | tie_bits(3) | tie_bits(4)));
    for (int g = 1; g < NG; g++) rd_chk(4'(4 + g), W'(7), "R9 line1 untied write");
    // R5 detail set beats clear, R9 tied clear
    det_ev = '0; det_ev[1] = 1'b1;
    bus_addr = 4'd2; bus_wdata = 32'h1 << 18; bus_wr = 1'b1;
    step();
    det_ev = '0; bus_wr = 1'b0;
    rd_chk(4'd4, W'(2), "R5 detail set wins");
    wr(4'd2, 32'h1 << 9);
    rd_chk(4'd4, '0, "R9 group0 cleared");
    for (int g = 1; g < NG; g++) begin
      logic [W-1:0] t;
      t = tie_bits(g);
      wr(4'd3, t & ~(t - 1));
      rd_chk(4'(4 + g), '0, "R9 tied group cleared");
      for (int h = g + 1; h < NG; h++) rd_chk(4'(4 + h), W'(7), "R9 other group kept");
    end

    // R10 read-only and unmapped
    wr(4'd0, 32'h0000_00F0);
    for (int a = 4; a < 16; a++) wr(4'(a), '1);
    for (int a = 4; a < 16; a++) rd_chk(4'(a), '0, "R10 ignored or unmapped");
    rd_chk(4'd0, 32'h0000_00F0, "R10 mask0 untouched");
    rd_chk(4'd1, '0, "R10 mask1 untouched");
    rd_chk(4'd2, '0, "R10 stat0 untouched");

    done = 1;
    report();
  end
endmodule